// File: doc/BRIEF.md
# Single-Error-Correcting Nibble Link Decoder

This block sits behind a serial-link deserializer and accepts one 10-bit word per clock whenever a word strobe is high. Each word carries a two-bit marker in bits 9:8, a data nibble in bits 7:4 and four check bits in bits 3:0. The block forms a 4-bit syndrome from the word and turns it into a 10-bit error pattern. The pattern is XORed into the word, which repairs any single flipped bit. Syndromes that name no bit position are flagged as uncorrectable.

Idle filler words, and any word one bit away from the idle value, bypass the decoder. After correction, a low-nibble word followed by a high-nibble word is reassembled into a byte, which appears on a registered output with a one-cycle valid strobe. Two saturating statistics counters run alongside. One counts words that needed any correction and the other counts uncorrectable words. A synchronous clear input zeroes both.

Top module: `lnk_sec_decoder`

## Requirements
- R1: The syndrome bits are s1 = w8^w6^w3^w2^w0, s2 = w8^w7^w6^w5^w4^w3, s3 = w9^w8^w5^w4^w2 and s4 = w9^w7^w6^w4^w1^w0. A nonzero syndrome equal to the column {s1,s2,s3,s4} of a single position (9:0011, 8:1110, 7:0101, 6:1101, 5:0110, 4:0111, 3:1100, 2:1010, 1:0001, 0:1001) flips that bit, so any single-bit error in a valid codeword is repaired before the marker and nibble are used.
- R2: A strobed word equal to 0000011111, or differing from it in exactly one bit, is idle. It delivers no byte, changes no counter and leaves a pending low nibble intact.
- R3: A strobed non-idle word whose syndrome is 1000, 1011, 1111, 0010 or 0100 maps to pattern 0000000011. It is uncorrectable: the uncorrectable counter and the bit-error counter each add one, no byte is delivered, and any pending low nibble is dropped.
- R4: A strobed non-idle word with a single-position syndrome adds one to the bit-error counter only. A word with a zero syndrome changes no counter.
- R5: After correction, marker 10 stores bits 7:4 as the low nibble. Marker 11 with a low nibble pending emits byte_out = {high nibble, low nibble}.
- R6: A high-nibble word with no pending low nibble emits nothing. A second low-nibble word replaces the pending one.
- R7: A strobed non-idle word whose corrected marker is 00 or 01 emits nothing and drops any pending low nibble.
- R8: byte_vld rises for exactly one cycle, in the cycle after the strobed high-nibble word. Counters change on the same edge that captures the word.
- R9: Each counter holds at all-ones and does not wrap.
- R10: stat_clr zeroes both counters on the next edge and wins over an increment in the same cycle.
- R11: Reset clears byte_vld, both counters and the pending low nibble.
- R12: With word_strobe low, word_in has no effect on outputs, counters or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_strobe | input | 1 | word_in holds a received word this cycle |
| word_in | input | 10 | Received 10-bit word |
| stat_clr | input | 1 | Synchronous clear of both counters |
| byte_vld | output | 1 | byte_out holds a reassembled byte |
| byte_out | output | 8 | Reassembled byte, high nibble in bits 7:4 |
| bit_err_cnt | output | CNT_W | Saturating count of words needing correction |
| word_err_cnt | output | CNT_W | Saturating count of uncorrectable words |

## Verification
The bench builds the block with CNT_W set to 4. At that width, each counter reaches all-ones after fifteen events, so saturation and its interaction with the clear are exercised in a few dozen words rather than billions. Every position's single-bit repair is driven. So are all idle variants placed between a low and a high nibble, and two-bit corruptions chosen to land on each unmapped syndrome.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    localparam int WORD_W = 10;
    localparam int SYN_W  = 4;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [WORD_W-1:0] IDLE_WORD   = 10'b0000011111;
    localparam logic [WORD_W-1:0] MULTI_ERR   = 10'b0000000011;

    typedef enum logic [1:0] {
        MK_NONE = 2'b00,
        MK_RSVD = 2'b01,
        MK_LOW  = 2'b10,
        MK_HIGH = 2'b11
    } marker_e;

    typedef struct packed {
        logic             idle;
        logic             fixed;
        logic             multi;
        marker_e          marker;
        logic [NIB_W-1:0] nib;
    } dec_word_t;

    // syndrome ordered {s1,s2,s3,s4}
    function automatic logic [SYN_W-1:0] calc_syndrome(input logic [WORD_W-1:0] w);
        logic s1, s2, s3, s4;
        s1 = w[8] ^ w[6] ^ w[3] ^ w[2] ^ w[0];
        s2 = w[8] ^ w[7] ^ w[6] ^ w[5] ^ w[4] ^ w[3];
        s3 = w[9] ^ w[8] ^ w[5] ^ w[4] ^ w[2];
        s4 = w[9] ^ w[7] ^ w[6] ^ w[4] ^ w[1] ^ w[0];
        return {s1, s2, s3, s4};
    endfunction

    function automatic logic [WORD_W-1:0] syn_to_pattern(input logic [SYN_W-1:0] s);
        logic [WORD_W-1:0] p;
        case (s)
            4'b0000: p = '0;
            4'b0011: p = 10'b1000000000;
            4'b1110: p = 10'b0100000000;
            4'b0101: p = 10'b0010000000;
            4'b1101: p = 10'b0001000000;
            4'b0110: p = 10'b0000100000;
            4'b0111: p = 10'b0000010000;
            4'b1100: p = 10'b0000001000;
            4'b1010: p = 10'b0000000100;
            4'b0001: p = 10'b0000000010;
            4'b1001: p = 10'b0000000001;
            default: p = MULTI_ERR;
        endcase
        return p;
    endfunction

    function automatic logic near_idle(input logic [WORD_W-1:0] w);
        return $countones(w ^ IDLE_WORD) <= 1;
    endfunction

endpackage

// File: rtl/lnk_syndrome_fix.sv
module lnk_syndrome_fix
    import lnk_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_word_t         dec
);
    logic [SYN_W-1:0]  syn;
    logic [WORD_W-1:0] pattern;
    logic [WORD_W-1:0] repaired;

    always_comb begin
        syn        = calc_syndrome(word);
        pattern    = syn_to_pattern(syn);
        repaired   = word ^ pattern;
        dec.idle   = near_idle(word);
        dec.multi  = (pattern == MULTI_ERR);
        dec.fixed  = (pattern != '0) && (pattern != MULTI_ERR);
        dec.marker = marker_e'(repaired[WORD_W-1 -: 2]);
        dec.nib    = repaired[WORD_W-3 -: NIB_W];
    end
endmodule

// File: rtl/lnk_nibble_pack.sv
module lnk_nibble_pack
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  dec_word_t         dec,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out
);
    logic             pend_q;
    logic [NIB_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            low_q    <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (take && !dec.idle) begin
                if (dec.multi) begin
                    pend_q <= 1'b0;
                end else begin
                    unique case (dec.marker)
                        MK_LOW: begin
                            pend_q <= 1'b1;
                            low_q  <= dec.nib;
                        end
                        MK_HIGH: begin
                            pend_q <= 1'b0;
                            if (pend_q) begin
                                byte_vld <= 1'b1;
                                byte_out <= {dec.nib, low_q};
                            end
                        end
                        default: pend_q <= 1'b0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/lnk_sat_counter.sv
module lnk_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/lnk_sec_decoder.sv
module lnk_sec_decoder
    import lnk_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_strobe,
    input  logic [9:0]        word_in,
    input  logic              stat_clr,
    output logic              byte_vld,
    output logic [7:0]        byte_out,
    output logic [CNT_W-1:0]  bit_err_cnt,
    output logic [CNT_W-1:0]  word_err_cnt
);
    localparam int N_STAT  = 2;
    localparam int ST_BIT  = 0;
    localparam int ST_WORD = 1;

    dec_word_t        dec;
    logic             live;
    logic [N_STAT-1:0] bump;
    logic [CNT_W-1:0] stat [N_STAT];

    lnk_syndrome_fix u_fix (
        .word (word_in),
        .dec  (dec)
    );

    lnk_nibble_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .take     (word_strobe),
        .dec      (dec),
        .byte_vld (byte_vld),
        .byte_out (byte_out)
    );

    always_comb begin
        live           = word_strobe && !dec.idle;
        bump[ST_BIT]   = live && (dec.fixed || dec.multi);
        bump[ST_WORD]  = live && dec.multi;
    end

    for (genvar g = 0; g < N_STAT; g++) begin : g_stat
        lnk_sat_counter #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (stat_clr),
            .inc (bump[g]),
            .cnt (stat[g])
        );
    end

    assign bit_err_cnt  = stat[ST_BIT];
    assign word_err_cnt = stat[ST_WORD];
endmodule

// File: rtl/lnk_sec_decoder_chk.sv
module lnk_sec_decoder_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             word_strobe,
    input logic [9:0]       word_in,
    input logic             stat_clr,
    input logic             byte_vld,
    input logic [CNT_W-1:0] bit_err_cnt,
    input logic [CNT_W-1:0] word_err_cnt
);
    localparam logic [CNT_W-1:0] FULL = '1;

    // R8: a byte needs a strobed word one cycle earlier
    a_r8_vld_after_strobe: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(word_strobe));

    // R9: saturated counter stays put
    a_r9_bit_sat: assert property (@(posedge clk) disable iff (rst)
        (bit_err_cnt == FULL && !stat_clr) |=> bit_err_cnt == FULL);

    a_r9_word_sat: assert property (@(posedge clk) disable iff (rst)
        (word_err_cnt == FULL && !stat_clr) |=> word_err_cnt == FULL);

    // R10: clear empties both counters
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> (bit_err_cnt == '0 && word_err_cnt == '0));

    // R4: bit counter steps by at most one
    a_r4_bit_step: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> (bit_err_cnt - $past(bit_err_cnt)) <= CNT_W'(1));

    // R12: no strobe, no counter motion
    a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
        (!word_strobe && !stat_clr) |=> ($stable(bit_err_cnt) && $stable(word_err_cnt) && !byte_vld));

    // R2: idle value itself touches nothing
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        (word_strobe && word_in == 10'b0000011111 && !stat_clr)
        |=> ($stable(bit_err_cnt) && $stable(word_err_cnt) && !byte_vld));

    // R3: an uncorrectable count also moves the bit counter unless full
    a_r3_pair: assert property (@(posedge clk) disable iff (rst)
        (!stat_clr && word_err_cnt != FULL) |=>
        (word_err_cnt == $past(word_err_cnt)) || (bit_err_cnt != $past(bit_err_cnt)) || (bit_err_cnt == FULL));
endmodule

bind lnk_sec_decoder lnk_sec_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_strobe  (word_strobe),
    .word_in      (word_in),
    .stat_clr     (stat_clr),
    .byte_vld     (byte_vld),
    .bit_err_cnt  (bit_err_cnt),
    .word_err_cnt (word_err_cnt)
);

// File: tb/tb_lnk_sec_decoder.sv
module tb_lnk_sec_decoder;
    localparam int CW = 4;
    localparam logic [CW-1:0] FULL = '1;
    localparam logic [9:0] IDLE = 10'b0000011111;

    logic clk = 0;
    logic rst = 1;
    logic word_strobe = 0;
    logic [9:0] word_in = '0;
    logic stat_clr = 0;
    logic byte_vld;
    logic [7:0] byte_out;
    logic [CW-1:0] bit_err_cnt, word_err_cnt;

    int total = 0;
    int bad = 0;

    logic [7:0] expq [$];
    logic       m_pend = 0;
    logic [3:0] m_low = '0;
    logic [CW-1:0] m_bit = '0, m_word = '0;

    always #2 clk = ~clk;

    lnk_sec_decoder #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .word_strobe(word_strobe), .word_in(word_in),
        .stat_clr(stat_clr), .byte_vld(byte_vld), .byte_out(byte_out),
        .bit_err_cnt(bit_err_cnt), .word_err_cnt(word_err_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // systematic encoder built from the R1 check equations
    function automatic logic [9:0] enc(input logic [1:0] mk, input logic [3:0] nib);
        logic [9:0] w;
        w = {mk, nib, 4'b0000};
        w[3] = w[8] ^ w[7] ^ w[6] ^ w[5] ^ w[4];
        w[2] = w[9] ^ w[8] ^ w[5] ^ w[4];
        w[0] = w[8] ^ w[6] ^ w[3] ^ w[2];
        w[1] = w[9] ^ w[7] ^ w[6] ^ w[4] ^ w[0];
        return w;
    endfunction

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == FULL) ? v : v + CW'(1);
    endfunction

    // monitor: pops expected bytes as they appear
    always @(negedge clk) begin
        if (!rst && byte_vld) begin
            if (expq.size() == 0) begin
                check("R5 unexpected byte", {24'h0, byte_out}, 32'hFFFF_FFFF);
            end else begin
                logic [7:0] e;
                e = expq.pop_front();
                check("R5 byte value", {24'h0, byte_out}, {24'h0, e});
            end
        end
    end

    // driver: one strobed word, model update, counter checks
    task automatic drive(input logic [9:0] w, input logic [1:0] mk, input logic [3:0] nib,
                         input int kind, input logic clr, input string tag);
        // kind: 0 clean, 1 one-bit fix, 2 uncorrectable
        logic idle_like, expect_byte;
        idle_like   = ($countones(w ^ IDLE) <= 1);
        expect_byte = 0;
        if (!idle_like) begin
            if (kind == 2) begin
                m_bit  = sat_inc(m_bit);
                m_word = sat_inc(m_word);
                m_pend = 0;
            end else begin
                if (kind == 1) m_bit = sat_inc(m_bit);
                if (mk == 2'b10) begin
                    m_pend = 1; m_low = nib;
                end else if (mk == 2'b11) begin
                    if (m_pend) begin
                        expq.push_back({nib, m_low});
                        expect_byte = 1;
                    end
                    m_pend = 0;
                end else begin
                    m_pend = 0;
                end
            end
        end
        if (clr) begin
            m_bit = '0; m_word = '0;
        end
        word_in = w; word_strobe = 1; stat_clr = clr;
        @(posedge clk); #1;
        word_strobe = 0; stat_clr = 0;
        check({tag, " R8 vld timing"}, {31'h0, byte_vld}, {31'h0, expect_byte});
        check({tag, " R4 bit count"}, {28'h0, bit_err_cnt}, {28'h0, m_bit});
        check({tag, " R3 word count"}, {28'h0, word_err_cnt}, {28'h0, m_word});
    endtask

    task automatic good(input logic [1:0] mk, input logic [3:0] nib, input int flip, input string tag);
        logic [9:0] w;
        w = enc(mk, nib);
        if (flip >= 0) w[flip] = ~w[flip];
        drive(w, mk, nib, (flip >= 0) ? 1 : 0, 1'b0, tag);
    endtask

    task automatic corrupt2(input logic [1:0] mk, input logic [3:0] nib, input int a, input int b,
                            input logic clr, input string tag);
        logic [9:0] w;
        w = enc(mk, nib);
        w[a] = ~w[a];
        w[b] = ~w[b];
        drive(w, mk, nib, 2, clr, tag);
    endtask

    initial begin
        #(4 * 200000);
        check("watchdog", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R11 reset vld", {31'h0, byte_vld}, 32'h0);
        check("R11 reset bitcnt", {28'h0, bit_err_cnt}, 32'h0);
        check("R11 reset wordcnt", {28'h0, word_err_cnt}, 32'h0);

        // R5 clean bytes
        good(2'b10, 4'h5, -1, "R5 low");
        good(2'b11, 4'hA, -1, "R5 high");
        good(2'b10, 4'hF, -1, "R5 low2");
        good(2'b11, 4'h0, -1, "R5 high2");

        // R1 every position repaired
        for (int p = 0; p < 10; p++) begin
            good(2'b10, 4'(p + 3), p, "R1 low fix");
            good(2'b11, 4'(12 - p), (9 - p), "R1 high fix");
        end

        // R2 idle and all its one-bit variants between halves
        good(2'b10, 4'h6, -1, "R2 low");
        drive(IDLE, 2'b00, 4'h0, 0, 1'b0, "R2 idle");
        for (int p = 0; p < 10; p++) begin
            logic [9:0] v;
            v = IDLE;
            v[p] = ~v[p];
            drive(v, 2'b00, 4'h0, 0, 1'b0, "R2 variant");
        end
        good(2'b11, 4'h9, -1, "R2 high kept");

        // R6 orphan high, low replaced
        good(2'b11, 4'h3, -1, "R6 orphan high");
        good(2'b10, 4'h1, -1, "R6 first low");
        good(2'b10, 4'h2, -1, "R6 second low");
        good(2'b11, 4'h4, -1, "R6 high");

        // R7 invalid markers drop pending
        good(2'b10, 4'h7, -1, "R7 low");
        good(2'b00, 4'h5, -1, "R7 marker00");
        good(2'b11, 4'h8, -1, "R7 high dropped");
        good(2'b10, 4'h7, -1, "R7 low b");
        good(2'b01, 4'hC, -1, "R7 marker01");
        good(2'b11, 4'h8, -1, "R7 high dropped b");

        // R3 unmapped syndromes drop pending
        good(2'b10, 4'hB, -1, "R3 low");
        corrupt2(2'b11, 4'h2, 1, 0, 1'b0, "R3 syn1000");
        good(2'b11, 4'h2, -1, "R3 high dropped");
        corrupt2(2'b10, 4'h6, 2, 8, 1'b0, "R3 syn0100");
        corrupt2(2'b10, 4'h6, 4, 7, 1'b0, "R3 syn0010");
        corrupt2(2'b11, 4'h6, 3, 4, 1'b0, "R3 syn1011");
        corrupt2(2'b11, 4'hD, 8, 1, 1'b0, "R3 syn1111");

        // R12 unstrobed garbage
        good(2'b10, 4'hE, -1, "R12 low");
        word_in = 10'b1111100000;
        repeat (4) @(posedge clk);
        #1;
        check("R12 bitcnt hold", {28'h0, bit_err_cnt}, {28'h0, m_bit});
        check("R12 vld low", {31'h0, byte_vld}, 32'h0);
        good(2'b11, 4'h1, -1, "R12 high kept");

        // R9 saturation
        for (int i = 0; i < 20; i++) corrupt2(2'b10, 4'h3, 1, 0, 1'b0, "R9 sat");
        check("R9 bit full", {28'h0, bit_err_cnt}, {28'h0, FULL});
        check("R9 word full", {28'h0, word_err_cnt}, {28'h0, FULL});

        // R10 clear wins over increment
        corrupt2(2'b10, 4'h3, 1, 0, 1'b1, "R10 clear");
        check("R10 bit zero", {28'h0, bit_err_cnt}, 32'h0);
        good(2'b10, 4'h4, 5, "R10 count again");
        good(2'b11, 4'h4, -1, "R10 clean high");

        @(negedge clk);
        @(negedge clk);
        check("R5 queue drained", expq.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule